// File: doc/BRIEF.md
# Cascadable Serial Sample Output Port

This block sends complex samples to a DSP serial port. Each sample, a pair of I and Q words produced in the core clock domain, is handed across to the serial clock domain and shifted out as a single frame: the I word first, then the Q word, each most significant bit first. The data line is driven only while the port is shifting its own frame. The pad enable `sdo_en` carries this: the line is high-impedance whenever `sdo_en` is low. Several ports can therefore share one wire to the DSP.

In master mode the port makes its own serial clock by dividing the core clock. It starts a frame by itself, with a one-period frame-sync pulse, as soon as a sample is waiting. In slave mode the serial clock and the frame sync come from outside, and the clock may be unrelated to the core clock. The sync can come from the DSP or from the frame-end output of an upstream port. When the sync comes from an upstream port, the downstream frame follows the upstream one with no idle bit between them. This lets any number of ports take turns on the same line.

Only one sample can be in flight at a time. A sample offered while the previous frame is still waiting or still shifting is dropped, and a sticky overrun flag is raised.

Top module: `cascade_sample_tx`

## Requirements
- R1: With parameter MODE_FROM_PIN = 0 the mode comes from `cfg_master`. With MODE_FROM_PIN = 1 it comes from `strap_master`, and the other input has no effect. In both cases 1 means master and 0 means slave.
- R2: A frame is 2*WORD_W bits. It carries the I word then the Q word, each MSB first, at one bit per serial clock period. The data changes on the rising edge of the serial clock.
- R3: `sdo_en` is high for exactly the 2*WORD_W consecutive bit periods of the port's own frame and low otherwise. A frame is never cut short.
- R4: In slave mode `sdfs_in` is sampled on the falling edge of `sclk_in`. When it is seen high and a sample is waiting, the first bit appears at the next rising edge. When no sample is waiting, the sync is ignored: no bits are sent and `sdfe` stays low.
- R5: A frame sync that arrives while a frame is being shifted has no effect on that frame and starts no extra frame.
- R6: `sdfe` is high for exactly one serial clock period, the one carrying the last Q bit, and is low otherwise. A downstream port fed by it drives its first bit in the very next period, leaving no gap on the shared line.
- R7: In master mode `sclk_out` has a period of 2*(div_half+1) core clock cycles. When a sample is waiting, the port raises `sdfs_out` for one serial period, and the first bit follows one period later. In slave mode `sdfs_out` stays low.
- R8: A sample offered before the previous frame has been fully shifted out is dropped and sets `overrun`. `overrun` stays set until reset. A sample offered after the previous frame has completed is accepted.
- R9: While `rst_n` is low, `sdo_en`, `sdfe`, `sdfs_out`, `sclk_out` and `overrun` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_core | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| cfg_master | input | 1 | Mode from configuration, 1 = master |
| strap_master | input | 1 | Mode from a dedicated pin, 1 = master |
| div_half | input | DIV_W | Master serial clock half period minus one, in core cycles |
| smp_valid | input | 1 | One-cycle strobe: a new sample is offered |
| smp_i | input | WORD_W | I word of the sample |
| smp_q | input | WORD_W | Q word of the sample |
| sclk_in | input | 1 | External serial clock (slave mode) |
| sdfs_in | input | 1 | External frame sync (slave mode) |
| sclk_out | output | 1 | Generated serial clock (master mode), low otherwise |
| sdfs_out | output | 1 | Generated frame-sync pulse (master mode) |
| sdo | output | 1 | Serial data bit |
| sdo_en | output | 1 | Drive enable for the serial data line |
| sdfe | output | 1 | Frame-end pulse on the last Q bit |
| overrun | output | 1 | Sticky flag: a sample was dropped |

## Verification
The assertions assume that the mode inputs and `div_half` do not change while `rst_n` is high, except that the divider may be widened. They also assume that an external frame sync is a single high period set up before a falling edge of the serial clock. The bench changes the mode only while reset is held, and drives `sdfs_in` just after a rising edge for one period. It offers each new sample only after the previous frame has had time to finish and the acknowledgement has crossed back, except when it is deliberately provoking an overrun. Two ports are chained on one shared line, so that the handoff and the absence of double drive are observed at the ports.

// File: rtl/cst_pkg.sv
`timescale 1ns/1ps
package cst_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SYNC  = 2'd1,
      ST_SHIFT = 2'd2
   } ser_state_e;

endpackage

// File: rtl/cst_sync.sv
`timescale 1ns/1ps
module cst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= 1'b0;
            else        chain[g] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= 1'b0;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/cst_divider.sv
`timescale 1ns/1ps
module cst_divider #(
   parameter int DIV_W = 8
) (
   input  logic             clk_core,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] div_half,
   output logic             sclk_gen
);
   logic [DIV_W-1:0] cnt_q;
   logic             clk_q;

   always_ff @(posedge clk_core or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         clk_q <= 1'b0;
      end else if (!en) begin
         cnt_q <= '0;
         clk_q <= 1'b0;
      end else if (cnt_q >= div_half) begin
         cnt_q <= '0;
         clk_q <= ~clk_q;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign sclk_gen = clk_q;
endmodule

// File: rtl/cst_handoff.sv
`timescale 1ns/1ps
module cst_handoff #(
   parameter int WORD_W = 16,
   parameter int SYNC_STAGES = 2,
   localparam int FRAME_W = 2 * WORD_W
) (
   input  logic               clk_core,
   input  logic               rst_n,
   input  logic               smp_valid,
   input  logic [WORD_W-1:0]  smp_i,
   input  logic [WORD_W-1:0]  smp_q,
   input  logic               ack_tgl,
   output logic [FRAME_W-1:0] hold,
   output logic               req_tgl,
   output logic               busy,
   output logic               overrun
);
   logic               ack_s;
   logic [FRAME_W-1:0] hold_q;
   logic               req_q;
   logic               ovr_q;

   cst_sync #(.STAGES(SYNC_STAGES)) ack_sync_i (
      .clk   (clk_core),
      .rst_n (rst_n),
      .d     (ack_tgl),
      .q     (ack_s)
   );

   assign busy = req_q ^ ack_s;

   always_ff @(posedge clk_core or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         req_q  <= 1'b0;
         ovr_q  <= 1'b0;
      end else if (smp_valid) begin
         if (busy) begin
            ovr_q <= 1'b1;
         end else begin
            hold_q <= {smp_i, smp_q};
            req_q  <= ~req_q;
         end
      end
   end

   assign hold    = hold_q;
   assign req_tgl = req_q;
   assign overrun = ovr_q;
endmodule

// File: rtl/cst_shifter.sv
`timescale 1ns/1ps
module cst_shifter #(
   parameter int WORD_W = 16,
   parameter int SYNC_STAGES = 2,
   localparam int FRAME_W = 2 * WORD_W,
   localparam int CNT_W = $clog2(FRAME_W)
) (
   input  logic               ser_clk,
   input  logic               rst_n,
   input  logic               is_master,
   input  logic               fs_ext,
   input  logic               req_tgl,
   input  logic [FRAME_W-1:0] hold,
   output logic               sdo,
   output logic               sdo_en,
   output logic               sdfe,
   output logic               sdfs_out,
   output logic               ack_tgl
);
   import cst_pkg::*;

   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);
   localparam logic [CNT_W-1:0] NEAR_END = CNT_W'(FRAME_W - 2);

   ser_state_e         st_q;
   logic [FRAME_W-1:0] sh_q;
   logic [CNT_W-1:0]   cnt_q;
   logic               oe_q, fe_q, fs_q, ack_q;
   logic               req_s, fs_neg;
   logic               pending, fs_src;

   cst_sync #(.STAGES(SYNC_STAGES)) req_sync_i (
      .clk   (ser_clk),
      .rst_n (rst_n),
      .d     (req_tgl),
      .q     (req_s)
   );

   assign pending = req_s ^ ack_q;
   assign fs_src  = is_master ? fs_q : fs_ext;

   // frame sync is captured on the falling edge
   always_ff @(negedge ser_clk or negedge rst_n) begin
      if (!rst_n) fs_neg <= 1'b0;
      else        fs_neg <= fs_src;
   end

   always_ff @(posedge ser_clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         sh_q  <= '0;
         cnt_q <= '0;
         oe_q  <= 1'b0;
         fe_q  <= 1'b0;
         fs_q  <= 1'b0;
         ack_q <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (fs_neg && pending) begin
                  sh_q  <= hold;
                  cnt_q <= '0;
                  oe_q  <= 1'b1;
                  st_q  <= ST_SHIFT;
               end else if (is_master && pending) begin
                  fs_q <= 1'b1;
                  st_q <= ST_SYNC;
               end
            end
            ST_SYNC: begin
               fs_q  <= 1'b0;
               sh_q  <= hold;
               cnt_q <= '0;
               oe_q  <= 1'b1;
               st_q  <= ST_SHIFT;
            end
            ST_SHIFT: begin
               if (cnt_q == LAST_BIT) begin
                  oe_q  <= 1'b0;
                  fe_q  <= 1'b0;
                  ack_q <= ~ack_q;
                  st_q  <= ST_IDLE;
               end else begin
                  sh_q  <= sh_q << 1;
                  cnt_q <= cnt_q + 1'b1;
                  fe_q  <= (cnt_q == NEAR_END);
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign sdo      = sh_q[FRAME_W-1];
   assign sdo_en   = oe_q;
   assign sdfe     = fe_q;
   assign sdfs_out = fs_q;
   assign ack_tgl  = ack_q;
endmodule

// File: rtl/cascade_sample_tx.sv
`timescale 1ns/1ps
module cascade_sample_tx #(
   parameter int WORD_W        = 16,
   parameter int DIV_W         = 8,
   parameter int SYNC_STAGES   = 2,
   parameter bit MODE_FROM_PIN = 1'b0
) (
   input  logic              clk_core,
   input  logic              rst_n,
   input  logic              cfg_master,
   input  logic              strap_master,
   input  logic [DIV_W-1:0]  div_half,
   input  logic              smp_valid,
   input  logic [WORD_W-1:0] smp_i,
   input  logic [WORD_W-1:0] smp_q,
   input  logic              sclk_in,
   input  logic              sdfs_in,
   output logic              sclk_out,
   output logic              sdfs_out,
   output logic              sdo,
   output logic              sdo_en,
   output logic              sdfe,
   output logic              overrun
);
   localparam int FRAME_W = 2 * WORD_W;

   if (WORD_W < 2) begin : g_bad_word
      $error("cascade_sample_tx: WORD_W must be at least 2");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("cascade_sample_tx: DIV_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("cascade_sample_tx: SYNC_STAGES must be at least 2");
   end

   logic               is_master;
   logic               sclk_gen;
   logic               ser_clk;
   logic [FRAME_W-1:0] hold;
   logic               req_tgl, ack_tgl, busy;

   assign is_master = MODE_FROM_PIN ? strap_master : cfg_master;

   cst_divider #(.DIV_W(DIV_W)) div_i (
      .clk_core (clk_core),
      .rst_n    (rst_n),
      .en       (is_master),
      .div_half (div_half),
      .sclk_gen (sclk_gen)
   );

   assign ser_clk  = is_master ? sclk_gen : sclk_in;
   assign sclk_out = sclk_gen;

   cst_handoff #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) hand_i (
      .clk_core  (clk_core),
      .rst_n     (rst_n),
      .smp_valid (smp_valid),
      .smp_i     (smp_i),
      .smp_q     (smp_q),
      .ack_tgl   (ack_tgl),
      .hold      (hold),
      .req_tgl   (req_tgl),
      .busy      (busy),
      .overrun   (overrun)
   );

   cst_shifter #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) shift_i (
      .ser_clk   (ser_clk),
      .rst_n     (rst_n),
      .is_master (is_master),
      .fs_ext    (sdfs_in),
      .req_tgl   (req_tgl),
      .hold      (hold),
      .sdo       (sdo),
      .sdo_en    (sdo_en),
      .sdfe      (sdfe),
      .sdfs_out  (sdfs_out),
      .ack_tgl   (ack_tgl)
   );
endmodule

// File: rtl/cst_checker.sv
`timescale 1ns/1ps
module cst_checker #(
   parameter int FRAME_W = 32
) (
   input logic               clk_core,
   input logic               ser_clk,
   input logic               rst_n,
   input logic               is_master,
   input logic               sdo_en,
   input logic               sdfe,
   input logic               sdfs_out,
   input logic               sclk_out,
   input logic               overrun,
   input logic               busy,
   input logic [FRAME_W-1:0] hold
);
   // R6
   fe_inside_frame_chk: assert property (@(posedge ser_clk) disable iff (!rst_n)
      sdfe |-> sdo_en);

   // R6
   fe_single_period_chk: assert property (@(posedge ser_clk) disable iff (!rst_n)
      sdfe |=> !sdfe);

   // R3
   release_after_end_chk: assert property (@(posedge ser_clk) disable iff (!rst_n)
      sdfe |=> !sdo_en);

   // R3 R5
   frame_unbroken_chk: assert property (@(posedge ser_clk) disable iff (!rst_n)
      (sdo_en && !sdfe) |=> sdo_en);

   // R7
   sync_pulse_width_chk: assert property (@(posedge ser_clk) disable iff (!rst_n)
      sdfs_out |=> !sdfs_out);

   // R7
   sync_then_data_chk: assert property (@(posedge ser_clk) disable iff (!rst_n)
      sdfs_out |=> sdo_en);

   // R7 R1
   sync_master_only_chk: assert property (@(posedge ser_clk) disable iff (!rst_n)
      sdfs_out |-> is_master);

   // R8
   overrun_sticky_chk: assert property (@(posedge clk_core) disable iff (!rst_n)
      overrun |=> overrun);

   // R8
   hold_stable_chk: assert property (@(posedge clk_core) disable iff (!rst_n)
      busy |=> $stable(hold));

   // R9
   always @(posedge clk_core) begin
      if (!rst_n) begin
         reset_quiet_chk: assert (!sdo_en && !sdfe && !sdfs_out && !sclk_out && !overrun);
      end
   end
endmodule

bind cascade_sample_tx cst_checker #(.FRAME_W(2 * WORD_W)) chk_i (
   .clk_core (clk_core),
   .ser_clk  (ser_clk),
   .rst_n    (rst_n),
   .is_master(is_master),
   .sdo_en   (sdo_en),
   .sdfe     (sdfe),
   .sdfs_out (sdfs_out),
   .sclk_out (sclk_out),
   .overrun  (overrun),
   .busy     (busy),
   .hold     (hold)
);

// File: tb/cascade_sample_tx_tb_top.sv
`timescale 1ns/1ps
module cascade_sample_tx_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int SCLK_HALF  = 23;
   localparam int W  = 16;
   localparam int F  = 2 * W;
   localparam int DW = 8;

   logic clk_core = 1'b0, rst_n = 1'b0, cfg_master = 1'b0, bench_sclk = 1'b0;
   logic [DW-1:0] div_half = 8'd1;
   logic valid_a = 1'b0, valid_b = 1'b0, sdfs_a_in = 1'b0;
   logic [W-1:0] i_a = '0, q_a = '0, i_b = '0, q_b = '0;
   logic sclk_out_a, sdfs_out_a, sdo_a, oe_a, fe_a, ovr_a;
   logic sclk_out_b, sdfs_out_b, sdo_b, oe_b, fe_b, ovr_b;
   logic ser_clk_tb;

   int n_checks = 0, n_fail = 0;
   logic [F-1:0] exp_q[$];

   always #(CLK_PERIOD/2) clk_core = ~clk_core;
   always #SCLK_HALF bench_sclk = ~bench_sclk;
   assign ser_clk_tb = cfg_master ? sclk_out_a : bench_sclk;

   // upstream port: mode from cfg_master, strap tied to master to show it is ignored
   cascade_sample_tx #(.WORD_W(W), .DIV_W(DW), .MODE_FROM_PIN(1'b0)) dut_i (
      .clk_core(clk_core), .rst_n(rst_n), .cfg_master(cfg_master), .strap_master(1'b1),
      .div_half(div_half), .smp_valid(valid_a), .smp_i(i_a), .smp_q(q_a),
      .sclk_in(bench_sclk), .sdfs_in(sdfs_a_in), .sclk_out(sclk_out_a),
      .sdfs_out(sdfs_out_a), .sdo(sdo_a), .sdo_en(oe_a), .sdfe(fe_a), .overrun(ovr_a));

   // downstream port: mode from strap tied to slave, cfg tied to master to show it is ignored
   cascade_sample_tx #(.WORD_W(W), .DIV_W(DW), .MODE_FROM_PIN(1'b1)) dn_i (
      .clk_core(clk_core), .rst_n(rst_n), .cfg_master(1'b1), .strap_master(1'b0),
      .div_half(div_half), .smp_valid(valid_b), .smp_i(i_b), .smp_q(q_b),
      .sclk_in(ser_clk_tb), .sdfs_in(fe_a), .sclk_out(sclk_out_b),
      .sdfs_out(sdfs_out_b), .sdo(sdo_b), .sdo_en(oe_b), .sdfe(fe_b), .overrun(ovr_b));

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
      end
   endtask

   task automatic send_a(input logic [W-1:0] iv, input logic [W-1:0] qv);
      @(posedge clk_core); #1 valid_a = 1'b1; i_a = iv; q_a = qv;
      @(posedge clk_core); #1 valid_a = 1'b0;
   endtask

   task automatic send_b(input logic [W-1:0] iv, input logic [W-1:0] qv);
      @(posedge clk_core); #1 valid_b = 1'b1; i_b = iv; q_b = qv;
      @(posedge clk_core); #1 valid_b = 1'b0;
   endtask

   task automatic expect_frame(input logic [W-1:0] iv, input logic [W-1:0] qv);
      exp_q.push_back({iv, qv});
   endtask

   task automatic pulse_fs();
      @(posedge bench_sclk); #1 sdfs_a_in = 1'b1;
      @(posedge bench_sclk); #1 sdfs_a_in = 1'b0;
   endtask

   task automatic wait_ser(input int n);
      repeat (n) @(posedge ser_clk_tb);
   endtask

   task automatic measure(input int d);
      time t0, t1;
      @(posedge sclk_out_a); t0 = $time;
      @(posedge sclk_out_a); t1 = $time;
      chk((t1 - t0) == time'(2 * (d + 1) * CLK_PERIOD), "R7", "sclk_out period ns",
          64'(t1 - t0), 64'(2 * (d + 1) * CLK_PERIOD));
   endtask

   // monitor: models the shared line and checks frames against the queue
   int edge_idx = 0, fs_at = -10, run = 0, last_run = 0, bitpos = 0, bits_seen = 0;
   int fs_hi_a = 0, fs_hi_b = 0;
   logic [F-1:0] shf = '0;
   bit fe_ok = 1'b1, prev_oe = 1'b0;

   always @(negedge ser_clk_tb) begin
      logic any_oe, bitv, fe_drv, fs_sig;
      logic [F-1:0] ev;
      any_oe = oe_a | oe_b;
      fs_sig = cfg_master ? sdfs_out_a : sdfs_a_in;
      if (fs_sig) fs_at = edge_idx;
      if (sdfs_out_a) fs_hi_a++;
      if (sdfs_out_b) fs_hi_b++;
      if (oe_a && oe_b) chk(1'b0, "R3", "two ports drive the line", 64'd2, 64'd1);
      if (any_oe) begin
         if (!prev_oe)
            chk(edge_idx == fs_at + 1, cfg_master ? "R7" : "R4",
                "first bit one period after sync", 64'(edge_idx - fs_at), 64'd1);
         bitv   = oe_a ? sdo_a : sdo_b;
         fe_drv = oe_a ? fe_a : fe_b;
         if (fe_drv != (bitpos == F - 1)) fe_ok = 1'b0;
         shf = {shf[F-2:0], bitv};
         bitpos++; run++; bits_seen++;
         if (bitpos == F) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R2", "unexpected frame", 64'(shf), 64'd0);
            end else begin
               ev = exp_q.pop_front();
               chk(shf == ev, "R2", "frame content I then Q", 64'(shf), 64'(ev));
            end
            chk(fe_ok, "R6", "sdfe only on last Q bit", 64'(fe_ok), 64'd1);
            fe_ok = 1'b1;
            bitpos = 0;
         end
      end else begin
         if (run != 0) last_run = run;
         run = 0;
         if (fe_a | fe_b) chk(1'b0, "R6", "sdfe while line idle", 64'd1, 64'd0);
         if (bitpos != 0) begin
            chk(1'b0, "R3", "frame cut short", 64'(bitpos), 64'(F));
            bitpos = 0;
         end
      end
      prev_oe = any_oe;
      edge_idx++;
   end

   initial begin
      repeat (100000) @(posedge clk_core);
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      // reset state, R9
      repeat (5) @(posedge clk_core);
      #1;
      chk(!oe_a && !oe_b, "R9", "sdo_en in reset", 64'({oe_a, oe_b}), 64'd0);
      chk(!fe_a && !fe_b, "R9", "sdfe in reset", 64'({fe_a, fe_b}), 64'd0);
      chk(!ovr_a && !ovr_b, "R9", "overrun in reset", 64'({ovr_a, ovr_b}), 64'd0);
      chk(!sdfs_out_a && !sclk_out_a, "R9", "sdfs_out/sclk_out in reset",
          64'({sdfs_out_a, sclk_out_a}), 64'd0);
      @(negedge clk_core); rst_n = 1'b1;
      wait_ser(4);

      // R4: sync with no sample waiting is ignored; R1: strap of dut_i ignored
      pulse_fs();
      wait_ser(40);
      chk(bits_seen == 0, "R4", "bits after sync with nothing waiting", 64'(bits_seen), 64'd0);
      chk(fs_hi_a == 0, "R1", "slave by cfg despite strap high", 64'(fs_hi_a), 64'd0);

      // single frame, R2 R3
      send_a(16'hA5A5, 16'h3C0F); expect_frame(16'hA5A5, 16'h3C0F);
      wait_ser(6); pulse_fs(); wait_ser(40);
      chk(last_run == F, "R3", "enable length single frame", 64'(last_run), 64'(F));
      chk(exp_q.size() == 0, "R2", "frame delivered", 64'(exp_q.size()), 64'd0);

      // cascade handoff, R6
      send_b(16'h1234, 16'h8001);
      send_a(16'hFFFF, 16'h0000);
      expect_frame(16'hFFFF, 16'h0000); expect_frame(16'h1234, 16'h8001);
      wait_ser(6); pulse_fs(); wait_ser(80);
      chk(last_run == 2 * F, "R6", "gapless two-port run", 64'(last_run), 64'(2 * F));
      chk(exp_q.size() == 0, "R6", "both frames delivered", 64'(exp_q.size()), 64'd0);

      // second sync mid frame, R5
      send_a(16'h0F0F, 16'hF0F0); expect_frame(16'h0F0F, 16'hF0F0);
      wait_ser(6); pulse_fs(); wait_ser(8); pulse_fs(); wait_ser(45);
      chk(last_run == F, "R5", "frame length with extra sync", 64'(last_run), 64'(F));
      chk(bits_seen == 4 * F, "R5", "no extra frame started", 64'(bits_seen), 64'(4 * F));

      // overrun, R8
      chk(ovr_a == 1'b0, "R8", "overrun before test", 64'(ovr_a), 64'd0);
      send_a(16'h1111, 16'h2222); expect_frame(16'h1111, 16'h2222);
      send_a(16'h3333, 16'h4444);
      repeat (2) @(posedge clk_core); #1;
      chk(ovr_a == 1'b1, "R8", "overrun on second sample", 64'(ovr_a), 64'd1);
      chk(ovr_b == 1'b0, "R8", "other port no overrun", 64'(ovr_b), 64'd0);
      wait_ser(4); pulse_fs(); wait_ser(45);
      send_a(16'h5555, 16'h6666); expect_frame(16'h5555, 16'h6666);
      wait_ser(6); pulse_fs(); wait_ser(45);
      chk(exp_q.size() == 0, "R8", "sample accepted after frame", 64'(exp_q.size()), 64'd0);
      chk(ovr_a == 1'b1, "R8", "overrun sticky", 64'(ovr_a), 64'd1);

      // master phase, R7 R1
      @(posedge clk_core); #1 rst_n = 1'b0;
      cfg_master = 1'b1; div_half = 8'd1;
      repeat (4) @(posedge clk_core); #1;
      chk(ovr_a == 1'b0, "R9", "reset clears overrun", 64'(ovr_a), 64'd0);
      @(negedge clk_core); rst_n = 1'b1;
      fs_hi_a = 0; fs_hi_b = 0;
      measure(1);
      send_b(16'hABCD, 16'h0123);
      send_a(16'h7E81, 16'hC3A5);
      expect_frame(16'h7E81, 16'hC3A5); expect_frame(16'hABCD, 16'h0123);
      wait_ser(90);
      chk(last_run == 2 * F, "R7", "master then cascade run", 64'(last_run), 64'(2 * F));
      chk(fs_hi_a == 1, "R7", "one sync period from master", 64'(fs_hi_a), 64'd1);
      chk(fs_hi_b == 0, "R1", "strap slave despite cfg high", 64'(fs_hi_b), 64'd0);
      chk(exp_q.size() == 0, "R7", "master frames delivered", 64'(exp_q.size()), 64'd0);

      send_a(16'h0001, 16'h8000); expect_frame(16'h0001, 16'h8000);
      wait_ser(50);
      chk(last_run == F, "R7", "master self start again", 64'(last_run), 64'(F));
      chk(fs_hi_a == 2, "R7", "second sync pulse", 64'(fs_hi_a), 64'd2);

      @(posedge clk_core); #1 div_half = 8'd3;
      wait_ser(4);
      measure(3);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule